// File: doc/BRIEF.md
# CCD Readout Pixel Region Classifier

This block follows the readout of a full-frame CCD sensor one sample at a time and labels every sample with the part of the sensor it came from. Three strobes drive it. A frame strobe restarts the position at line 0, column 0. A line strobe advances to the next line and puts the column back at 0. A pixel strobe marks one sample and moves the column on by one. From the line and column it derives a region code: dummy shift phase, light-shielded dark reference, charge-transfer test line or column, unshielded buffer ring, tested image area, or overflow.

For buffer and image samples the block also gives the colour-filter channel. A short strip of leading buffer columns is always blue. All other buffer and image samples follow a 2x2 Bayer tile whose phase is fixed at the first Bayer pixel. Two qualifier flags mark the samples that downstream logic may use for dark-level estimation and for image data. The outputs are registered and appear one clock after the pixel strobe. The active width and height are parameters. The sizes of the dummy, dark, buffer and blue regions are also parameters, with defaults taken from the sensor geometry.

Top module: `ccd_pixel_tagger`

## Requirements
Column index c counts the pixel strobes since the last line or frame start, starting at 0. Row index r counts the line starts since the frame start, starting at 0. With the defaults (ACT_W=8, ACT_H=4), a line holds LEN=106 samples and a frame holds HGT=98 lines. Region codes are: 0 dummy, 1 dark, 2 buffer, 3 image, 4 test, 5 overflow. Colour codes are: 0 none, 1 red, 2 green on a red row, 3 green on a blue row, 4 blue.
- R1: Columns 0..19 are tagged dummy (0) on every row inside the frame, with colour 0, and are never flagged as dark reference.
- R2: Columns 20..55 are tagged dark (1) with the dark-reference flag set on every row inside the frame.
- R3: On rows 0..29 and on the last 23 rows (r = 75..97), every column from 20 to LEN-1 is tagged dark (1), with the dark-reference flag set and colour 0.
- R4: Row 30, column 56 and column LEN-1 are tagged test (4) wherever no dark or dummy rule applies, with colour 0 and both flags low.
- R5: Buffer samples are tagged 2 with both flags low. They cover rows 31..50 and 55..74, and columns 57..76 and 77+ACT_W..96+ACT_W, within the rows and columns not claimed by the rules above.
- R6: Rows 51..50+ACT_H crossed with columns 77..76+ACT_W are tagged image (3) with the image flag set.
- R7: On buffer and image samples, columns 57..60 have colour 4. Elsewhere the colour is 1 + 2*((r-31) mod 2) + ((c-61) mod 2). All other regions have colour 0.
- R8: A sample with c >= LEN, or one on a row r >= HGT, is tagged overflow (5) with colour 0 and both flags low. The column and row counts saturate at LEN and HGT.
- R9: A frame strobe puts the position at row 0, column 0 and wins over a line strobe in the same cycle. A pixel strobe in the same cycle as a line or frame strobe is column 0 of the new line.
- R10: Reset clears all outputs to 0. The tag-valid output is high exactly one cycle after each pixel strobe. The flags can only be high together with tag-valid. Region and colour hold their values between tags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_stb | input | 1 | One sample is shifted out in this cycle |
| line_stb | input | 1 | A new line starts in this cycle |
| frame_stb | input | 1 | A new frame starts in this cycle |
| region_o | output | 3 | Region code of the last tagged sample |
| colour_o | output | 3 | Colour-filter code of the last tagged sample |
| tag_vld_o | output | 1 | Region and colour were updated at the last edge |
| dark_vld_o | output | 1 | The tagged sample is a usable dark reference |
| img_vld_o | output | 1 | The tagged sample is a tested image pixel |

## Verification
The scoreboard first drives a complete frame with one pixel strobe in every cycle, where each line strobe shares its cycle with the first sample of the line. This shows whether every region boundary and the Bayer phase land on the right column and row. A second frame has gaps between strobes, line strobes in cycles without a sample, and lines that run past their length. This separates correct column counting from counting clock cycles, and it shows column saturation. A third pass runs more lines than the frame height to show row overflow. A last pass restarts the frame in the middle of a line, with both start strobes at once, to check which strobe takes priority.

// File: rtl/ccd_tag_pkg.sv
package ccd_tag_pkg;

  typedef enum logic [2:0] {
    RG_DUMMY  = 3'd0,
    RG_DARK   = 3'd1,
    RG_BUFFER = 3'd2,
    RG_IMAGE  = 3'd3,
    RG_TEST   = 3'd4,
    RG_OVER   = 3'd5
  } region_e;

  typedef enum logic [2:0] {
    CF_NONE  = 3'd0,
    CF_RED   = 3'd1,
    CF_GRN_R = 3'd2,
    CF_GRN_B = 3'd3,
    CF_BLUE  = 3'd4
  } colour_e;

  typedef enum logic [2:0] {
    CZ_DUMMY, CZ_SHIELD, CZ_CTE, CZ_BLUE, CZ_EDGE, CZ_CORE, CZ_PAST
  } col_zone_e;

  typedef enum logic [2:0] {
    RZ_SHIELD, RZ_CTE, RZ_EDGE, RZ_CORE, RZ_PAST
  } row_zone_e;

  // Sensor geometry, all sizes in samples or lines
  typedef struct packed {
    int unsigned dummy_n;
    int unsigned dark_cols;
    int unsigned edge_n;
    int unsigned blue_n;
    int unsigned dark_top;
    int unsigned dark_bot;
    int unsigned act_w;
    int unsigned act_h;
  } geom_t;

  function automatic int unsigned line_len(geom_t g);
    return g.dummy_n + g.dark_cols + 2 + 2 * g.edge_n + g.act_w;
  endfunction

  function automatic int unsigned frame_h(geom_t g);
    return g.dark_top + 1 + 2 * g.edge_n + g.act_h + g.dark_bot;
  endfunction

  function automatic int unsigned bayer_col0(geom_t g);
    return g.dummy_n + g.dark_cols + 1 + g.blue_n;
  endfunction

  function automatic int unsigned bayer_row0(geom_t g);
    return g.dark_top + 1;
  endfunction

  // Walk the column boundaries from the left edge of the line
  function automatic col_zone_e col_zone(geom_t g, int unsigned c);
    int unsigned b;
    b = g.dummy_n;
    if (c < b) return CZ_DUMMY;
    b = b + g.dark_cols;
    if (c < b) return CZ_SHIELD;
    b = b + 1;
    if (c < b) return CZ_CTE;
    b = b + g.blue_n;
    if (c < b) return CZ_BLUE;
    b = b + g.edge_n - g.blue_n;
    if (c < b) return CZ_EDGE;
    b = b + g.act_w;
    if (c < b) return CZ_CORE;
    b = b + g.edge_n;
    if (c < b) return CZ_EDGE;
    b = b + 1;
    if (c < b) return CZ_CTE;
    return CZ_PAST;
  endfunction

  // Walk the row boundaries from the top of the frame
  function automatic row_zone_e row_zone(geom_t g, int unsigned r);
    int unsigned b;
    b = g.dark_top;
    if (r < b) return RZ_SHIELD;
    b = b + 1;
    if (r < b) return RZ_CTE;
    b = b + g.edge_n;
    if (r < b) return RZ_EDGE;
    b = b + g.act_h;
    if (r < b) return RZ_CORE;
    b = b + g.edge_n;
    if (r < b) return RZ_EDGE;
    b = b + g.dark_bot;
    if (r < b) return RZ_SHIELD;
    return RZ_PAST;
  endfunction

  // Bayer phase from parity relative to the first Bayer pixel
  function automatic colour_e bayer_colour(geom_t g, int unsigned c, int unsigned r);
    int unsigned dc;
    int unsigned dr;
    dc = c - bayer_col0(g);
    dr = r - bayer_row0(g);
    case ({dr[0], dc[0]})
      2'b00:   return CF_RED;
      2'b01:   return CF_GRN_R;
      2'b10:   return CF_GRN_B;
      default: return CF_BLUE;
    endcase
  endfunction

endpackage

// File: rtl/ccd_pos_track.sv
module ccd_pos_track #(
  parameter int unsigned LINE_LEN = 106,
  parameter int unsigned FRAME_H  = 98,
  parameter int unsigned COL_W    = 7,
  parameter int unsigned ROW_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_stb,
  input  logic             line_stb,
  input  logic             frame_stb,
  output logic [COL_W-1:0] pos_col_o,
  output logic [ROW_W-1:0] pos_row_o
);

  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] eff_col;
  logic [ROW_W-1:0] eff_row;
  logic [COL_W-1:0] nxt_col;
  logic             col_full;
  logic             row_full;

  assign col_full = (eff_col == COL_W'(LINE_LEN));
  assign row_full = (row_q == ROW_W'(FRAME_H));

  // Position that the current strobe refers to
  always_comb begin
    if (frame_stb) begin
      eff_row = '0;
    end else if (line_stb && !row_full) begin
      eff_row = row_q + ROW_W'(1);
    end else begin
      eff_row = row_q;
    end
    eff_col = (frame_stb || line_stb) ? '0 : col_q;
  end

  assign nxt_col = (pix_stb && !col_full) ? eff_col + COL_W'(1) : eff_col;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else begin
      col_q <= nxt_col;
      row_q <= eff_row;
    end
  end

  assign pos_col_o = eff_col;
  assign pos_row_o = eff_row;

endmodule

// File: rtl/ccd_region_decode.sv
module ccd_region_decode
  import ccd_tag_pkg::*;
#(
  parameter geom_t       GEOM  = '0,
  parameter int unsigned COL_W = 7,
  parameter int unsigned ROW_W = 7
) (
  input  logic [COL_W-1:0] col_i,
  input  logic [ROW_W-1:0] row_i,
  output region_e          region_o,
  output colour_e          colour_o,
  output logic             dark_hit_o,
  output logic             image_hit_o
);

  col_zone_e cz;
  row_zone_e rz;

  always_comb begin
    cz          = col_zone(GEOM, 32'(col_i));
    rz          = row_zone(GEOM, 32'(row_i));
    region_o    = RG_BUFFER;
    colour_o    = CF_NONE;
    dark_hit_o  = 1'b0;
    image_hit_o = 1'b0;
    if (cz == CZ_PAST || rz == RZ_PAST) begin
      region_o = RG_OVER;
    end else if (cz == CZ_DUMMY) begin
      region_o = RG_DUMMY;
    end else if (rz == RZ_SHIELD || cz == CZ_SHIELD) begin
      region_o   = RG_DARK;
      dark_hit_o = 1'b1;
    end else if (rz == RZ_CTE || cz == CZ_CTE) begin
      region_o = RG_TEST;
    end else begin
      colour_o = (cz == CZ_BLUE) ? CF_BLUE
                                 : bayer_colour(GEOM, 32'(col_i), 32'(row_i));
      if (rz == RZ_CORE && cz == CZ_CORE) begin
        region_o    = RG_IMAGE;
        image_hit_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ccd_tag_stage.sv
module ccd_tag_stage
  import ccd_tag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pix_stb,
  input  region_e    region_i,
  input  colour_e    colour_i,
  input  logic       dark_hit_i,
  input  logic       image_hit_i,
  output logic [2:0] region_o,
  output logic [2:0] colour_o,
  output logic       tag_vld_o,
  output logic       dark_vld_o,
  output logic       img_vld_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      region_o   <= '0;
      colour_o   <= '0;
      tag_vld_o  <= 1'b0;
      dark_vld_o <= 1'b0;
      img_vld_o  <= 1'b0;
    end else begin
      tag_vld_o  <= pix_stb;
      dark_vld_o <= pix_stb && dark_hit_i;
      img_vld_o  <= pix_stb && image_hit_i;
      if (pix_stb) begin
        region_o <= region_i;
        colour_o <= colour_i;
      end
    end
  end

endmodule

// File: rtl/ccd_pixel_tagger.sv
module ccd_pixel_tagger
  import ccd_tag_pkg::*;
#(
  parameter int unsigned DUMMY_PHASES   = 20,
  parameter int unsigned DARK_LEAD      = 36,
  parameter int unsigned EDGE_PIX       = 20,
  parameter int unsigned BLUE_LEAD      = 4,
  parameter int unsigned DARK_TOP_LINES = 30,
  parameter int unsigned DARK_BOT_LINES = 23,
  parameter int unsigned ACT_W          = 8,
  parameter int unsigned ACT_H          = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pix_stb,
  input  logic       line_stb,
  input  logic       frame_stb,
  output logic [2:0] region_o,
  output logic [2:0] colour_o,
  output logic       tag_vld_o,
  output logic       dark_vld_o,
  output logic       img_vld_o
);

  localparam geom_t GEOM = '{
    dummy_n:   DUMMY_PHASES,
    dark_cols: DARK_LEAD,
    edge_n:    EDGE_PIX,
    blue_n:    BLUE_LEAD,
    dark_top:  DARK_TOP_LINES,
    dark_bot:  DARK_BOT_LINES,
    act_w:     ACT_W,
    act_h:     ACT_H
  };
  localparam int unsigned LINE_LEN = line_len(GEOM);
  localparam int unsigned FRAME_H  = frame_h(GEOM);
  localparam int unsigned COL_W    = $clog2(LINE_LEN + 1);
  localparam int unsigned ROW_W    = $clog2(FRAME_H + 1);

  // Named internal events
  logic [COL_W-1:0] pos_col;
  logic [ROW_W-1:0] pos_row;
  region_e          cur_region;
  colour_e          cur_colour;
  logic             dark_hit;
  logic             image_hit;

  ccd_pos_track #(
    .LINE_LEN (LINE_LEN),
    .FRAME_H  (FRAME_H),
    .COL_W    (COL_W),
    .ROW_W    (ROW_W)
  ) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_stb   (pix_stb),
    .line_stb  (line_stb),
    .frame_stb (frame_stb),
    .pos_col_o (pos_col),
    .pos_row_o (pos_row)
  );

  ccd_region_decode #(
    .GEOM  (GEOM),
    .COL_W (COL_W),
    .ROW_W (ROW_W)
  ) u_dec (
    .col_i       (pos_col),
    .row_i       (pos_row),
    .region_o    (cur_region),
    .colour_o    (cur_colour),
    .dark_hit_o  (dark_hit),
    .image_hit_o (image_hit)
  );

  ccd_tag_stage u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_stb     (pix_stb),
    .region_i    (cur_region),
    .colour_i    (cur_colour),
    .dark_hit_i  (dark_hit),
    .image_hit_i (image_hit),
    .region_o    (region_o),
    .colour_o    (colour_o),
    .tag_vld_o   (tag_vld_o),
    .dark_vld_o  (dark_vld_o),
    .img_vld_o   (img_vld_o)
  );

endmodule

// File: rtl/ccd_pixel_tagger_chk.sv
module ccd_pixel_tagger_chk
  import ccd_tag_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       pix_stb,
  input logic       frame_stb,
  input logic [2:0] region_o,
  input logic [2:0] colour_o,
  input logic       tag_vld_o,
  input logic       dark_vld_o,
  input logic       img_vld_o
);

  // R10
  tag_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_stb |=> tag_vld_o);

  // R10
  no_tag_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_stb |=> !tag_vld_o);

  // R10
  flags_need_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dark_vld_o || img_vld_o) |-> tag_vld_o);

  // R10
  hold_between_tags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_stb |=> ($stable(region_o) && $stable(colour_o)));

  // R1
  dummy_not_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_vld_o && region_o == RG_DUMMY) |-> (!dark_vld_o && colour_o == CF_NONE));

  // R3
  dark_flag_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dark_vld_o |-> (region_o == RG_DARK && !img_vld_o));

  // R4
  test_excluded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_vld_o && region_o == RG_TEST) |-> (!dark_vld_o && !img_vld_o));

  // R6
  image_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    img_vld_o |-> (region_o == RG_IMAGE && colour_o != CF_NONE));

  // R8
  overflow_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_vld_o && region_o == RG_OVER) |-> (colour_o == CF_NONE && !dark_vld_o && !img_vld_o));

  // R9
  frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_stb && frame_stb) |=> (region_o == RG_DUMMY));

endmodule

bind ccd_pixel_tagger ccd_pixel_tagger_chk u_chk (.*);

// File: tb/ccd_pixel_tagger_bench.sv
module ccd_pixel_tagger_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W   = 8;
  localparam int H   = 4;
  // Column landmarks
  localparam int C_DARK  = 20;
  localparam int C_CTE   = 56;
  localparam int C_BLUE1 = 61;
  localparam int C_ACT   = 77;
  localparam int LEN     = C_ACT + W + 20 + 1;
  // Row landmarks
  localparam int R_CTE   = 30;
  localparam int R_ACT   = 51;
  localparam int R_BOT   = R_ACT + H + 20;
  localparam int HGT     = R_BOT + 23;

  typedef struct {
    int    rgn;
    int    col;
    int    dk;
    int    im;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_stb = 1'b0;
  logic line_stb = 1'b0;
  logic frame_stb = 1'b0;
  logic [2:0] region_o;
  logic [2:0] colour_o;
  logic tag_vld_o;
  logic dark_vld_o;
  logic img_vld_o;

  int checks = 0;
  int errors = 0;
  int mr = 0;
  int mc = 0;
  bit done = 1'b0;
  exp_t exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  ccd_pixel_tagger #(.ACT_W(W), .ACT_H(H)) u_ccd_pixel_tagger (
    .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .line_stb(line_stb),
    .frame_stb(frame_stb), .region_o(region_o), .colour_o(colour_o),
    .tag_vld_o(tag_vld_o), .dark_vld_o(dark_vld_o), .img_vld_o(img_vld_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Independent expectation for row r, column c
  function automatic exp_t model(input int r, input int c, input string tag);
    exp_t e;
    e.rgn = 2; e.col = 0; e.dk = 0; e.im = 0;
    if (c >= LEN || r >= HGT) begin
      e.rgn = 5; e.tag = "R8";
    end else if (c < C_DARK) begin
      e.rgn = 0; e.tag = "R1";
    end else if (c < C_CTE) begin
      e.rgn = 1; e.dk = 1; e.tag = "R2";
    end else if (r < R_CTE || r >= R_BOT) begin
      e.rgn = 1; e.dk = 1; e.tag = "R3";
    end else if (r == R_CTE || c == C_CTE || c == LEN - 1) begin
      e.rgn = 4; e.tag = "R4";
    end else begin
      if (c < C_BLUE1) e.col = 4;
      else e.col = 1 + 2 * ((r - (R_CTE + 1)) % 2) + ((c - C_BLUE1) % 2);
      if (r >= R_ACT && r < R_ACT + H && c >= C_ACT && c < C_ACT + W) begin
        e.rgn = 3; e.im = 1; e.tag = "R6";
      end else begin
        e.tag = "R5";
      end
    end
    if (tag != "") e.tag = tag;
    return e;
  endfunction

  // Driver: one cycle of strobes, expected tag pushed for each sample
  task automatic drive(input bit p, input bit ls, input bit fs, input string tag);
    @(negedge clk);
    pix_stb = p; line_stb = ls; frame_stb = fs;
    if (fs) begin
      mr = 0; mc = 0;
    end else if (ls) begin
      if (mr < HGT) mr++;
      mc = 0;
    end
    if (p) begin
      exp_q.push_back(model(mr, mc, tag));
      if (mc < LEN) mc++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_stb = 1'b0; line_stb = 1'b0; frame_stb = 1'b0;
    end
  endtask

  // Monitor: compare each produced tag with the oldest expectation
  always @(negedge clk) begin
    if (rst_n) begin
      if (tag_vld_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10", "tag without strobe", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(int'(region_o) == e.rgn, e.tag, "region", int'(region_o), e.rgn);
          chk(int'(colour_o) == e.col, "R7", "colour", int'(colour_o), e.col);
          chk({dark_vld_o, img_vld_o} == {e.dk[0], e.im[0]}, e.tag, "flags",
              int'({dark_vld_o, img_vld_o}), int'({e.dk[0], e.im[0]}));
        end
      end else if (dark_vld_o || img_vld_o) begin
        chk(1'b0, "R10", "flag without tag", int'({dark_vld_o, img_vld_o}), 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Reset state (R10)
    repeat (3) @(negedge clk);
    chk(region_o == 3'd0 && colour_o == 3'd0, "R10", "reset region/colour",
        int'({region_o, colour_o}), 0);
    chk(!tag_vld_o && !dark_vld_o && !img_vld_o, "R10", "reset flags",
        int'({tag_vld_o, dark_vld_o, img_vld_o}), 0);
    rst_n = 1'b1;

    // Frame 1: back-to-back samples, line strobe shares the first sample (R9)
    for (int l = 0; l < HGT; l++) begin
      for (int c = 0; c < LEN; c++)
        drive(1'b1, (l != 0) && (c == 0), (l == 0) && (c == 0), "");
    end
    idle(4);

    // Frame 2: gapped samples, starts in idle cycles, lines overrun (R8)
    drive(1'b0, 1'b0, 1'b1, "");
    for (int l = 0; l < 56; l++) begin
      if (l != 0) drive(1'b0, 1'b1, 1'b0, "");
      for (int c = 0; c < LEN + 3; c++) begin
        drive(1'b1, 1'b0, 1'b0, "");
        drive(1'b0, 1'b0, 1'b0, "");
      end
    end
    idle(4);

    // Frame 3: more lines than the frame holds (R8 row overflow)
    for (int l = 0; l < HGT + 3; l++) begin
      drive(1'b0, l != 0, l == 0, "");
      for (int c = 0; c < ((l >= HGT - 2) ? LEN + 2 : 2); c++)
        drive(1'b1, 1'b0, 1'b0, "");
    end
    idle(4);

    // Restart in mid line, both strobes together: frame wins (R9)
    drive(1'b1, 1'b0, 1'b1, "");
    for (int c = 0; c < 40; c++) drive(1'b1, 1'b0, 1'b0, "");
    drive(1'b1, 1'b1, 1'b0, "");
    for (int c = 0; c < 60; c++) drive(1'b1, 1'b0, 1'b0, "");
    drive(1'b1, 1'b1, 1'b1, "R9");
    for (int c = 0; c < 25; c++) drive(1'b1, 1'b0, 1'b0, "R9");
    drive(1'b0, 1'b0, 1'b1, "");
    drive(1'b0, 1'b1, 1'b0, "");
    for (int c = 0; c < 22; c++) drive(1'b1, 1'b0, 1'b0, "R9");
    idle(4);

    chk(exp_q.size() == 0, "R10", "pending tags", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule